// File: doc/BRIEF.md
# Grouped Fixed-Priority DMA Channel Arbiter

This block decides which DMA channel the transfer engine serves next. Channels are split into groups. Every group has a programmable priority level, and so does every channel. Whenever the engine reports that it is idle, the arbiter works in two stages. First it picks the most urgent group that has a pending request. It then picks the most urgent requesting channel inside that group. A request can come from a channel's peripheral hardware line or from software. Only hardware requests receive a handshake acknowledge.

The arbiter also detects priority collisions as it runs. If two groups share a level, any arbitration raises a global group error. If two channels share a level inside the group that has just won, a channel error is raised. A channel collision inside a group that did not win raises nothing. An arbitration with a collision still reports the selection it made, but it starts no transfer. It can also raise an error interrupt if the selected channel has its interrupt enabled. The error flags stay set until software clears them by writing ones.

Top module: `grpDmaArb`

## Requirements
- R1: The winning group is the one with the highest group priority value (0 or 1) among the groups that have any hardware or software request. When group priorities are equal, the lowest-numbered requesting group wins.
- R2: Inside the winning group, the requesting channel with the highest 4-bit priority value is selected. The selected channel is reported as group*16 + channel.
- R3: When engIdle is high and at least one request is pending, selValid and selCh appear exactly one cycle later. With engIdle low, or with no request, selValid stays low.
- R4: hwAck pulses together with xferStart only if the selected channel's hwReq bit was set. A software-only request gets xferStart with hwAck low.
- R5: If any two group priority registers hold equal values, every arbitration sets the sticky flag grpPrioErr, whichever group is requesting.
- R6: chPrioErr is set only when the winning group contains two channels with equal priority values. Duplicate values in a group that does not win have no effect.
- R7: An arbitration that raises either priority error still pulses selValid, but it holds xferStart and hwAck low.
- R8: errIrq becomes set, and stays set, when an arbitration raises a priority error while the irq-enable bit of the selected channel is 1. With that bit 0, errIrq is not set.
- R9: A write to address 35 clears chPrioErr with data bit 0, grpPrioErr with data bit 1 and errIrq with data bit 2. A data bit of 0 leaves the matching flag unchanged.
- R10: Write-port map: addresses 0-31 hold channel priorities (data bits 3:0); addresses 32-33 hold group priorities (data bit 0); address 34 holds the 32-bit irq-enable mask. Reset values: channel c has priority c mod 16, group g has priority g, all irq enables are 0, and all flags are 0.
- R11: While a lower-priority group is being served, a request in a higher-priority group wins at the very next arbitration, even if the lower group still has requests pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| engIdle | input | 1 | Engine idle; arbitrate in this cycle |
| hwReq | input | 32 | Per-channel hardware request lines |
| swReq | input | 32 | Per-channel software requests |
| cfgWrValid | input | 1 | Configuration write strobe |
| cfgWrAddr | input | 6 | Configuration write address |
| cfgWrData | input | 32 | Configuration write data |
| selValid | output | 1 | One-cycle pulse: an arbitration result is valid |
| selCh | output | 5 | Selected channel (group*16 + channel) |
| xferStart | output | 1 | One-cycle pulse: start the transfer for selCh |
| hwAck | output | 1 | Hardware handshake acknowledge for selCh |
| chPrioErr | output | 1 | Sticky channel priority collision flag |
| grpPrioErr | output | 1 | Sticky group priority collision flag |
| errIrq | output | 1 | Sticky error interrupt request |

## Verification
All arbitration results come one register stage after the cycle in which engIdle is high. The driver queues the expected item while it applies the stimulus before a rising edge. The monitor pops that item a quarter period after the edge, so every result is compared in the one cycle where it is due. In cycles with nothing queued, the monitor checks that selValid is low. Configuration writes and clears take effect at the edge after the write. The flags are therefore sampled at the following falling edge. selCh is not compared after an arbitration that hit a channel collision, because the channel is undefined in that case.

// File: rtl/grpDmaArbPkg.sv
package grpDmaArbPkg;
  typedef struct packed {
    logic chPrioWe;
    logic grpPrioWe;
    logic irqEnWe;
    logic clrWe;
    logic arbGo;
  } arbStrobes_t;
endpackage

// File: rtl/prioPick.sv
module prioPick #(
  parameter int N = 16,
  parameter int W = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][W-1:0] prio,
  input  logic [N-1:0]        req,
  output logic [IW-1:0]       pickIdx,
  output logic                pickValid,
  output logic                dup
);
  logic [W-1:0] best;

  // Scan downward; ">=" lets the lower index win a tie.
  always_comb begin
    best      = '0;
    pickIdx   = '0;
    pickValid = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i] && (!pickValid || prio[i] >= best)) begin
        pickValid = 1'b1;
        best      = prio[i];
        pickIdx   = IW'(i);
      end
    end
  end

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        if (prio[i] == prio[j]) dup = 1'b1;
  end
endmodule

// File: rtl/arbCtrl.sv
module arbCtrl
  import grpDmaArbPkg::*;
#(
  parameter int NUM_CH     = 32,
  parameter int NUM_GROUPS = 2,
  parameter int ADDR_W     = 6,
  parameter int CH_W       = 5
) (
  input  logic              engIdle,
  input  logic              cfgWrValid,
  input  logic [ADDR_W-1:0] cfgWrAddr,
  output arbStrobes_t       strb,
  output logic [CH_W-1:0]   wrIdx
);
  localparam int GRP_BASE = NUM_CH;
  localparam int EN_ADDR  = NUM_CH + NUM_GROUPS;
  localparam int CLR_ADDR = EN_ADDR + 1;

  always_comb begin
    strb       = '0;
    wrIdx      = '0;
    strb.arbGo = engIdle;
    if (cfgWrValid) begin
      if (cfgWrAddr < ADDR_W'(GRP_BASE)) begin
        strb.chPrioWe = 1'b1;
        wrIdx         = CH_W'(cfgWrAddr);
      end else if (cfgWrAddr < ADDR_W'(EN_ADDR)) begin
        strb.grpPrioWe = 1'b1;
        wrIdx          = CH_W'(cfgWrAddr - ADDR_W'(GRP_BASE));
      end else if (cfgWrAddr == ADDR_W'(EN_ADDR)) begin
        strb.irqEnWe = 1'b1;
      end else if (cfgWrAddr == ADDR_W'(CLR_ADDR)) begin
        strb.clrWe = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arbDatapath.sv
module arbDatapath
  import grpDmaArbPkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int CHS_PER_GROUP = 16,
  parameter int CH_PRIO_W = 4,
  parameter int GRP_PRIO_W = 1,
  localparam int NUM_CH = NUM_GROUPS * CHS_PER_GROUP,
  localparam int GRP_IDX_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int CH_IDX_W = (CHS_PER_GROUP > 1) ? $clog2(CHS_PER_GROUP) : 1,
  localparam int CH_W = GRP_IDX_W + CH_IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbStrobes_t       strb,
  input  logic [CH_W-1:0]   wrIdx,
  input  logic [NUM_CH-1:0] wrData,
  input  logic [NUM_CH-1:0] hwReq,
  input  logic [NUM_CH-1:0] swReq,
  output logic              selValid,
  output logic [CH_W-1:0]   selCh,
  output logic              xferStart,
  output logic              hwAck,
  output logic              chPrioErr,
  output logic              grpPrioErr,
  output logic              errIrq
);
  logic [NUM_CH-1:0][CH_PRIO_W-1:0]      chPrio;
  logic [NUM_GROUPS-1:0][GRP_PRIO_W-1:0] grpPrio;
  logic [NUM_CH-1:0]                     irqEn;

  logic [NUM_CH-1:0]                     reqAll;
  logic [NUM_GROUPS-1:0][CH_IDX_W-1:0]   chIdx;
  logic [NUM_GROUPS-1:0]                 grpAny;
  logic [NUM_GROUPS-1:0]                 chDup;
  logic [GRP_IDX_W-1:0]                  actGrp;
  logic                                  anyReq, grpDup;
  logic [CH_W-1:0]                       selNext;
  logic                                  doArb, setCh, setGrp, errNow;

  assign reqAll = hwReq | swReq;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGrp
    prioPick #(.N(CHS_PER_GROUP), .W(CH_PRIO_W)) uChPick (
      .prio      (chPrio[g*CHS_PER_GROUP +: CHS_PER_GROUP]),
      .req       (reqAll[g*CHS_PER_GROUP +: CHS_PER_GROUP]),
      .pickIdx   (chIdx[g]),
      .pickValid (grpAny[g]),
      .dup       (chDup[g])
    );
  end

  prioPick #(.N(NUM_GROUPS), .W(GRP_PRIO_W)) uGrpPick (
    .prio      (grpPrio),
    .req       (grpAny),
    .pickIdx   (actGrp),
    .pickValid (anyReq),
    .dup       (grpDup)
  );

  assign selNext = {actGrp, chIdx[actGrp]};
  assign doArb   = strb.arbGo & anyReq;
  assign setCh   = doArb & chDup[actGrp];
  assign setGrp  = doArb & grpDup;
  assign errNow  = setCh | setGrp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) chPrio[i] <= CH_PRIO_W'(i % CHS_PER_GROUP);
      for (int g = 0; g < NUM_GROUPS; g++) grpPrio[g] <= GRP_PRIO_W'(g);
      irqEn      <= '0;
      selValid   <= 1'b0;
      selCh      <= '0;
      xferStart  <= 1'b0;
      hwAck      <= 1'b0;
      chPrioErr  <= 1'b0;
      grpPrioErr <= 1'b0;
      errIrq     <= 1'b0;
    end else begin
      if (strb.chPrioWe)  chPrio[wrIdx] <= wrData[CH_PRIO_W-1:0];
      if (strb.grpPrioWe) grpPrio[wrIdx[GRP_IDX_W-1:0]] <= wrData[GRP_PRIO_W-1:0];
      if (strb.irqEnWe)   irqEn <= wrData;
      selValid  <= doArb;
      xferStart <= doArb & ~errNow;
      hwAck     <= doArb & ~errNow & hwReq[selNext];
      if (doArb) selCh <= selNext;
      chPrioErr  <= (chPrioErr  & ~(strb.clrWe & wrData[0])) | setCh;
      grpPrioErr <= (grpPrioErr & ~(strb.clrWe & wrData[1])) | setGrp;
      errIrq     <= (errIrq     & ~(strb.clrWe & wrData[2])) | (errNow & irqEn[selNext]);
    end
  end

  a_r3_result_follows_go: assert property (@(posedge clk) disable iff (!rstN)
    (strb.arbGo && |reqAll) |=> selValid);
  a_r3_quiet_without_go: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.arbGo && |reqAll) |=> !selValid);
  a_r2_pick_requested: assert property (@(posedge clk) disable iff (!rstN)
    anyReq |-> reqAll[selNext]);
  a_r7_start_only_with_sel: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |-> selValid);
  a_r4_ack_only_with_start: assert property (@(posedge clk) disable iff (!rstN)
    hwAck |-> xferStart);
  a_r5_grp_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (grpPrioErr && !(strb.clrWe && wrData[1])) |=> grpPrioErr);
  a_r8_irq_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errIrq) |-> (chPrioErr || grpPrioErr));
endmodule

// File: rtl/grpDmaArb.sv
module grpDmaArb
  import grpDmaArbPkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int CHS_PER_GROUP = 16,
  parameter int CH_PRIO_W = 4,
  parameter int GRP_PRIO_W = 1,
  localparam int NUM_CH = NUM_GROUPS * CHS_PER_GROUP,
  localparam int ADDR_W = $clog2(NUM_CH + NUM_GROUPS + 2),
  localparam int GRP_IDX_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int CH_IDX_W = (CHS_PER_GROUP > 1) ? $clog2(CHS_PER_GROUP) : 1,
  localparam int CH_W = GRP_IDX_W + CH_IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              engIdle,
  input  logic [NUM_CH-1:0] hwReq,
  input  logic [NUM_CH-1:0] swReq,
  input  logic              cfgWrValid,
  input  logic [ADDR_W-1:0] cfgWrAddr,
  input  logic [NUM_CH-1:0] cfgWrData,
  output logic              selValid,
  output logic [CH_W-1:0]   selCh,
  output logic              xferStart,
  output logic              hwAck,
  output logic              chPrioErr,
  output logic              grpPrioErr,
  output logic              errIrq
);
  arbStrobes_t     strb;
  logic [CH_W-1:0] wrIdx;

  arbCtrl #(.NUM_CH(NUM_CH), .NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W), .CH_W(CH_W)) uCtrl (
    .engIdle    (engIdle),
    .cfgWrValid (cfgWrValid),
    .cfgWrAddr  (cfgWrAddr),
    .strb       (strb),
    .wrIdx      (wrIdx)
  );

  arbDatapath #(.NUM_GROUPS(NUM_GROUPS), .CHS_PER_GROUP(CHS_PER_GROUP),
                .CH_PRIO_W(CH_PRIO_W), .GRP_PRIO_W(GRP_PRIO_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrIdx      (wrIdx),
    .wrData     (cfgWrData),
    .hwReq      (hwReq),
    .swReq      (swReq),
    .selValid   (selValid),
    .selCh      (selCh),
    .xferStart  (xferStart),
    .hwAck      (hwAck),
    .chPrioErr  (chPrioErr),
    .grpPrioErr (grpPrioErr),
    .errIrq     (errIrq)
  );
endmodule

// File: tb/sim_grpDmaArb.sv
module sim_grpDmaArb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        engIdle;
  logic [31:0] hwReq, swReq;
  logic        cfgWrValid;
  logic [5:0]  cfgWrAddr;
  logic [31:0] cfgWrData;
  logic        selValid, xferStart, hwAck, chPrioErr, grpPrioErr, errIrq;
  logic [4:0]  selCh;

  always #(CLK_PERIOD/2) clk = ~clk;

  grpDmaArb u0 (
    .clk(clk), .rstN(rstN), .engIdle(engIdle), .hwReq(hwReq), .swReq(swReq),
    .cfgWrValid(cfgWrValid), .cfgWrAddr(cfgWrAddr), .cfgWrData(cfgWrData),
    .selValid(selValid), .selCh(selCh), .xferStart(xferStart), .hwAck(hwAck),
    .chPrioErr(chPrioErr), .grpPrioErr(grpPrioErr), .errIrq(errIrq)
  );

  typedef struct {
    logic [4:0] ch;
    bit         chkCh;
    logic       start, ack, cErr, gErr, irq;
    string      tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int   nChecks = 0;
  int   nErr = 0;
  bit   monOn = 0;

  // reference state mirrored from the requirements
  logic [3:0]  mCh[32];
  logic        mGrp[2];
  logic [31:0] mEn;
  logic        mCE, mGE, mIrq;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    cfgWrValid = 1'b1; cfgWrAddr = 6'(addr); cfgWrData = data;
    if (addr < 32) mCh[addr] = data[3:0];
    else if (addr < 34) mGrp[addr-32] = data[0];
    else if (addr == 34) mEn = data;
    else if (addr == 35) begin
      if (data[0]) mCE = 1'b0;
      if (data[1]) mGE = 1'b0;
      if (data[2]) mIrq = 1'b0;
    end
    @(negedge clk);
    cfgWrValid = 1'b0;
  endtask

  task automatic arb(input logic [31:0] hw, input logic [31:0] sw, input bit idle, input string tag);
    logic [31:0] r;
    int bg, bc, sel;
    bit cDup, gDup, err;
    exp_t x;
    @(negedge clk);
    hwReq = hw; swReq = sw; engIdle = idle;
    r = hw | sw;
    if (idle && r != 0) begin
      bg = -1;
      for (int g = 1; g >= 0; g--)
        if (|r[g*16 +: 16] && (bg < 0 || mGrp[g] >= mGrp[bg])) bg = g;
      bc = -1;
      for (int c = 15; c >= 0; c--)
        if (r[bg*16+c] && (bc < 0 || mCh[bg*16+c] >= mCh[bg*16+bc])) bc = c;
      sel = bg*16 + bc;
      gDup = (mGrp[0] == mGrp[1]);
      cDup = 0;
      for (int i = 0; i < 16; i++)
        for (int j = i + 1; j < 16; j++)
          if (mCh[bg*16+i] == mCh[bg*16+j]) cDup = 1;
      err = gDup | cDup;
      if (cDup) mCE = 1'b1;
      if (gDup) mGE = 1'b1;
      if (err && mEn[sel]) mIrq = 1'b1;
      x.ch = 5'(sel); x.chkCh = !cDup; x.start = !err; x.ack = !err && hw[sel];
      x.cErr = mCE; x.gErr = mGE; x.irq = mIrq; x.tag = tag;
      q.push_back(x);
    end
    @(negedge clk);
    hwReq = '0; swReq = '0; engIdle = 1'b0;
  endtask

  // monitor: results are due one edge after the stimulus
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (monOn) begin
      if (q.size() > 0) begin
        e = q.pop_front();
        chk({e.tag, " R3 selValid"}, selValid, 1);
        if (e.chkCh) chk({e.tag, " R2 selCh"}, selCh, e.ch);
        chk({e.tag, " R7 xferStart"}, xferStart, e.start);
        chk({e.tag, " R4 hwAck"}, hwAck, e.ack);
        chk({e.tag, " R6 chPrioErr"}, chPrioErr, e.cErr);
        chk({e.tag, " R5 grpPrioErr"}, grpPrioErr, e.gErr);
        chk({e.tag, " R8 errIrq"}, errIrq, e.irq);
      end else begin
        chk("R3 no result expected", selValid, 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

  initial begin
    rstN = 1'b0; engIdle = 1'b0; hwReq = '0; swReq = '0;
    cfgWrValid = 1'b0; cfgWrAddr = '0; cfgWrData = '0;
    for (int c = 0; c < 32; c++) mCh[c] = 4'(c % 16);
    mGrp[0] = 1'b0; mGrp[1] = 1'b1; mEn = '0; mCE = 0; mGE = 0; mIrq = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset selValid", selValid, 0);
    chk("R10 reset chPrioErr", chPrioErr, 0);
    chk("R10 reset grpPrioErr", grpPrioErr, 0);
    chk("R10 reset errIrq", errIrq, 0);
    monOn = 1;

    // R2 default priorities: ch10 beats ch3
    arb(32'h0, (32'h1 << 3) | (32'h1 << 10), 1, "R2 default prio");
    // R1 group1 beats group0 by default; then swap group priorities (R10)
    arb(32'h0, (32'h1 << 5) | (32'h1 << 20), 1, "R1 group1 wins");
    wr(32, 1); wr(33, 0);
    arb(32'h0, (32'h1 << 5) | (32'h1 << 20), 1, "R1 R10 group0 wins");
    wr(32, 0); wr(33, 1);
    // R4 hardware vs software acknowledge
    arb(32'h1 << 20, 32'h0, 1, "R4 hw request");
    arb(32'h0, 32'h1 << 20, 1, "R4 sw request");
    // R3 not idle: nothing happens
    arb(32'hFFFF_FFFF, 32'h0, 0, "R3 engine busy");
    // R11 lower group served until higher group requests
    arb(32'h0000_00F0, 32'h0, 1, "R11 low group");
    arb(32'h0000_00F0, 32'h0, 1, "R11 low group again");
    arb(32'h0001_00F0, 32'h0, 1, "R11 high group preempts");

    // R6 duplicate in group1 while group0 wins
    wr(16, 2); wr(17, 2); wr(32, 1); wr(33, 0);
    arb(32'h0, (32'h1 << 3) | (32'h1 << 17), 1, "R6 dup in losing group");
    arb(32'h0, 32'h1 << 20, 1, "R6 R7 dup in winning group irq off");
    wr(35, 32'h1);
    chk("R9 clear chPrioErr", chPrioErr, 0);
    wr(34, 32'hFFFF_FFFF);
    arb(32'h1 << 20, 32'h0, 1, "R8 dup with irq on");
    wr(35, 32'h1);
    chk("R9 bit0 clears chPrioErr", chPrioErr, 0);
    chk("R9 errIrq untouched", errIrq, 1);
    wr(35, 32'h7);
    chk("R9 errIrq cleared", errIrq, 0);
    wr(16, 0); wr(17, 1); wr(32, 0); wr(33, 1); wr(34, 0);

    // R5 group collision: global, lowest group wins the tie
    wr(33, 0);
    arb(32'h0, 32'h1 << 25, 1, "R5 group dup");
    arb(32'h0, (32'h1 << 4) | (32'h1 << 25), 1, "R1 R5 group tie lowest");
    wr(35, 32'h2);
    chk("R9 clear grpPrioErr", grpPrioErr, 0);
    wr(33, 1);

    // randomised configurations, some with collisions
    for (int k = 0; k < 30; k++) begin
      bit uniq;
      int off;
      uniq = ($urandom % 2) == 1;
      off = $urandom % 16;
      for (int c = 0; c < 32; c++)
        wr(c, uniq ? 32'((c + off) % 16) : 32'($urandom % 16));
      wr(32, $urandom % 2);
      wr(33, $urandom % 2);
      wr(34, ($urandom % 2) ? 32'hFFFF_FFFF : 32'h0);
      wr(35, 32'h7);
      for (int n = 0; n < 10; n++)
        arb($urandom & $urandom, $urandom & $urandom & $urandom, ($urandom % 4) != 0, "R1 R2 random");
    end

    repeat (3) @(negedge clk);
    chk("R3 queue drained", q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end
endmodule